// File: doc/BRIEF.md
# ADC Read-Only Serial Slave

This block is the device end of a two-wire serial bus for a single-channel 12-bit converter that can only be read. It oversamples the clock and data lines in the system clock domain, finds START and STOP conditions, and compares the incoming address byte against a fixed four-bit prefix `1001` joined to three strap bits. A matching read request is acknowledged, and a sample-start strobe goes to the converter. The result then goes back as two bytes, the upper one padded with zeros.

While the master acknowledges each lower byte, the block keeps sending fresh results. Each new conversion is started on the clock falling edge that ends the last data bit, so no new address phase is needed. The bus is driven only through an open-drain enable: `sda_oe` high pulls the line low. A small register model stands in for the converter. It captures `analog_code` on the strobe and presents it as the result a fixed number of cycles later.

The controller has eight named states. IDLE waits for a START. ADDR shifts in eight address bits. ADDR_ACK pulls SDA low for the acknowledge slot. TX_HI shifts out the padded upper byte. MACK_HI releases SDA for the master's acknowledge. TX_LO shifts out the lower byte. MACK_LO samples the master's final acknowledge. WAIT ignores all traffic until the next START or STOP. The transitions are:
- IDLE to ADDR on a START.
- ADDR to ADDR_ACK on a match, or to WAIT on a mismatch or a write.
- ADDR_ACK to TX_HI on a clock fall.
- TX_HI to MACK_HI after eight bits.
- MACK_HI to TX_LO on an acknowledge, or to WAIT on a NAK.
- TX_LO to MACK_LO after eight bits.
- MACK_LO to TX_HI on an acknowledge, or to WAIT on a NAK.
- Any state to ADDR on a START.
- Any state to IDLE on a STOP.

Top module: `adc_rd_slave`

## Requirements
- R1: A request is answered only when the seven address bits equal `1001` followed by `addr_sel[2:0]` (MSB first) and the eighth bit is 1. Otherwise SDA stays released and no strobe fires.
- R2: After a matching read address, the slave holds SDA low for the whole high phase of the ninth clock pulse.
- R3: `sample_strobe` is a single system-clock pulse. It fires on the SCL falling edge that ends the read/write bit of a matching read address.
- R4: The first data byte is `0000` followed by result bits 11 to 8, sent MSB first.
- R5: The second data byte is result bits 7 to 0, sent MSB first.
- R6: On the SCL falling edge that ends the lower-byte LSB, a new strobe fires. If the master then acknowledges (SDA low), a fresh two-byte result follows with no address phase.
- R7: After a NAK on the lower byte, SDA stays released and no strobe fires for any further clock pulses until a START.
- R8: A START at any point restarts address matching. A STOP at any point returns the slave to idle with SDA released.
- R9: Out of reset, and during every master-driven bit including the acknowledge slots, `sda_oe` is 0.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin (wired level) |
| addr_sel | input | 3 | Strap bits forming the low three address bits |
| analog_code | input | 12 | Value the converter model digitises on a strobe |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| sample_strobe | output | 1 | One-cycle sample-start pulse to the converter |

## Verification
A wrong state appears at the ports within one bit time. A missed or extra transition shifts every later data bit, corrupting the byte read back on the next eight clock pulses. A stuck acknowledge or transmit state leaves SDA low where the master expects a released line, so the very next sampled bit is wrong. Strobe misplacement shows as a wrong strobe count at the acknowledge slot, or as stale data in the following frame. Released-bus checks after NAK, mismatch and STOP show whether the slave truly ignores traffic.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX_HI,
        ST_MACK_HI,
        ST_TX_LO,
        ST_MACK_LO,
        ST_WAIT
    } slv_state_t;

    localparam logic [3:0] ADDR_PREFIX = 4'b1001;
    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/adc_sample_model.sv
module adc_sample_model #(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] code_in,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    logic [DATA_W-1:0] hold_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            cnt_q  <= '0;
            result <= '0;
        end else if (start) begin
            hold_q <= code_in;
            cnt_q  <= CNT_W'(LATENCY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                result <= hold_q;
            end
        end
    end
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [2:0]        addr_sel,
    input  logic [DATA_W-1:0] result,
    output logic              sda_oe,
    output logic              strobe
);
    localparam int unsigned PAD_W = 2 * BYTE_W - DATA_W;
    localparam int unsigned HI_W  = DATA_W - BYTE_W;

    slv_state_t        state_q, state_d;
    logic [3:0]        bit_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] lo_q;
    logic              mack_q;
    logic              start_cond, stop_cond, addr_hit, last_bit;

    assign start_cond = scl_lvl & sda_fall;
    assign stop_cond  = scl_lvl & sda_rise;
    assign addr_hit   = (rx_q[7:1] == {ADDR_PREFIX, addr_sel}) & rx_q[0];
    assign last_bit   = (bit_q == 4'd7);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_cond) begin
            state_d = ST_IDLE;
        end else if (start_cond) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_q == 4'd8)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_TX_HI;
                ST_TX_HI:    if (scl_fall && last_bit) state_d = ST_MACK_HI;
                ST_MACK_HI:  if (scl_fall) state_d = mack_q ? ST_WAIT : ST_TX_LO;
                ST_TX_LO:    if (scl_fall && last_bit) state_d = ST_MACK_LO;
                ST_MACK_LO:  if (scl_fall) state_d = mack_q ? ST_WAIT : ST_TX_HI;
                ST_WAIT:     state_d = ST_WAIT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            lo_q   <= '0;
            mack_q <= 1'b1;
        end else if (start_cond || stop_cond) begin
            bit_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (scl_rise && bit_q < 4'd8) begin
                        rx_q  <= {rx_q[6:0], sda_lvl};
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_ADDR_ACK, ST_MACK_LO: begin
                    if (state_q == ST_MACK_LO && scl_rise) mack_q <= sda_lvl;
                    if (scl_fall) begin
                        tx_q  <= {{PAD_W{1'b0}}, result[DATA_W-1 -: HI_W]};
                        lo_q  <= result[BYTE_W-1:0];
                        bit_q <= '0;
                    end
                end
                ST_TX_HI, ST_TX_LO: begin
                    if (scl_fall) begin
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        bit_q <= last_bit ? 4'd0 : bit_q + 1'b1;
                    end
                end
                ST_MACK_HI: begin
                    if (scl_rise) mack_q <= sda_lvl;
                    if (scl_fall) begin
                        tx_q  <= lo_q;
                        bit_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        strobe = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK:        sda_oe = 1'b1;
            ST_TX_HI, ST_TX_LO: sda_oe = ~tx_q[BYTE_W-1];
            default:            sda_oe = 1'b0;
        endcase
        if (!start_cond && !stop_cond && scl_fall) begin
            if (state_q == ST_ADDR && bit_q == 4'd8 && addr_hit) strobe = 1'b1;
            if (state_q == ST_TX_LO && last_bit)                 strobe = 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_slave.sv
module adc_rd_slave #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned LATENCY     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        addr_sel,
    input  logic [DATA_W-1:0] analog_code,
    output logic              sda_oe,
    output logic              sample_strobe
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic [DATA_W-1:0] conv_result;

    adc_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(scl_in),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    adc_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(sda_in),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    adc_sample_model #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_model (
        .clk(clk), .rst_n(rst_n), .start(sample_strobe),
        .code_in(analog_code), .result(conv_result)
    );

    adc_rd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_lvl(scl_lvl),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .addr_sel(addr_sel), .result(conv_result),
        .sda_oe(sda_oe), .strobe(sample_strobe)
    );
endmodule

// File: rtl/adc_rd_slave_chk.sv
module adc_rd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic sda_oe,
    input logic sample_strobe
);
    logic c1, c2, d1, d2, d3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1 <= 1'b1; c2 <= 1'b1;
            d1 <= 1'b1; d2 <= 1'b1; d3 <= 1'b1;
        end else begin
            c1 <= scl_in; c2 <= c1;
            d1 <= sda_in; d2 <= d1; d3 <= d2;
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);                       // R3
    AST_STROBE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> !c2);                                  // R6
    AST_OE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (c2 && $past(c2)) |-> $stable(sda_oe));                  // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (c2 && d2 && !d3) |=> !sda_oe);                          // R8
endmodule

bind adc_rd_slave adc_rd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_oe(sda_oe), .sample_strobe(sample_strobe)
);

// File: tb/adc_rd_slave_tb.sv
`timescale 1ns/1ps
module adc_rd_slave_tb;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  addr_sel = 3'b101;
    logic [11:0] analog_code = '0;
    logic        sda_oe, sample_strobe;
    wire         sda_line = sda_m & ~sda_oe;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    int r10_viol = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    adc_rd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .analog_code(analog_code),
        .sda_oe(sda_oe), .sample_strobe(sample_strobe)
    );

    always @(posedge clk) if (rst_n && sample_strobe) strobes++;

    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) r10_viol++;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    function automatic logic [7:0] exp_hi(input logic [11:0] c);
        return {4'b0000, c[11:8]};
    endfunction
    function automatic logic [7:0] exp_lo(input logic [11:0] c);
        return c[7:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask
    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask
    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask
    task automatic read_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask
    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask
    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
    endtask

    // one streamed frame; the next code is presented before the lower-byte LSB
    task automatic read_frame(input logic [11:0] cur, input logic [11:0] nxt, input logic ack);
        logic [7:0] hi, lo;
        int s0;
        read_byte(hi);
        chk(hi == exp_hi(cur), "R4 upper byte", hi, exp_hi(cur));
        send_bit(1'b0);
        analog_code = nxt;
        s0 = strobes;
        read_byte(lo);
        chk(lo == exp_lo(cur), "R5 lower byte", lo, exp_lo(cur));
        chk(strobes == s0 + 1, "R6 strobe at LSB fall", strobes, s0 + 1);
        send_bit(ack);
    endtask

    task automatic addr_phase(input logic [7:0] a, input bit expect_ack);
        logic b;
        int s0;
        s0 = strobes;
        bus_start();
        send_byte(a);
        read_bit(b);
        if (expect_ack) begin
            chk(b == 1'b0, "R2 address acknowledge", b, 0);
            chk(strobes == s0 + 1, "R3 strobe after read bit", strobes, s0 + 1);
        end else begin
            chk(b == 1'b1, "R1 no acknowledge", b, 1);
            chk(strobes == s0, "R1 no strobe", strobes, s0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [11:0] c0, c1;
        int s0, frames;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && sample_strobe == 1'b0, "R9 reset outputs", {sda_oe, sample_strobe}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // directed: corner codes, single frame then NAK
        c0 = 12'hFFF;
        analog_code = c0;
        addr_phase({4'b1001, addr_sel, 1'b1}, 1);
        read_frame(c0, 12'h000, 1'b1);
        s0 = strobes;
        read_byte(v);
        chk(v == 8'hFF, "R7 released after NAK", v, 8'hFF);
        chk(strobes == s0, "R7 no strobe after NAK", strobes, s0);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released after STOP", sda_oe, 0);

        // mismatched address and write request
        addr_phase({4'b1001, ~addr_sel, 1'b1}, 0);
        addr_phase({4'b1011, addr_sel, 1'b1}, 0);
        addr_phase({4'b1001, addr_sel, 1'b0}, 0);
        s0 = strobes;
        read_byte(v);
        chk(v == 8'hFF && strobes == s0, "R1 ignored after mismatch", v, 8'hFF);
        bus_stop();

        // abort in the middle of an address with a repeated START
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        c0 = 12'h800;
        analog_code = c0;
        addr_phase({4'b1001, addr_sel, 1'b1}, 1);
        read_frame(c0, 12'h000, 1'b0);
        read_frame(12'h000, 12'h5A5, 1'b1);
        bus_stop();

        // random transactions with streaming
        for (int t = 0; t < 16; t++) begin
            addr_sel = 3'($urandom);
            frames = 1 + int'($urandom % 4);
            c0 = 12'($urandom);
            analog_code = c0;
            addr_phase({4'b1001, addr_sel, 1'b1}, 1);
            for (int f = 0; f < frames; f++) begin
                c1 = 12'($urandom);
                read_frame(c0, c1, (f == frames - 1));
                c0 = c1;
            end
            bus_stop();
            chk(sda_oe == 1'b0, "R9 idle release", sda_oe, 0);
        end

        chk(r10_viol == 0, "R10 oe stable while SCL high", r10_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule